// File: doc/BRIEF.md
# USB Host Interrupt Pacing Controller

This block holds a slice of a USB host controller's command register, together with the logic that spaces out its interrupts. Software uses a small register bus to program three things: a threshold that sets the maximum interrupt rate, the asynchronous schedule enable, and a doorbell that asks the schedule engine to drop its cached asynchronous state. A micro-frame tick drives a threshold counter. Status events from several sources are collected in write-1-to-clear bits. The single interrupt line is raised only when the counter completes an interval while an enabled status bit is pending.

The doorbell hands off to the schedule engine. While it is set and the asynchronous schedule is enabled, the block holds its eviction request output high. When the engine answers with an eviction-complete pulse, the block sets the async-advance status bit and clears the doorbell itself. The interrupt for that status bit then waits for the next interval boundary like any other source.

Top module: `usb_intr_pacer`

## Requirements
- R1: After reset, the command register (address 0) reads 0x0008_0000, i.e. threshold 8. Status (address 1) and enable (address 2) read 0. `irq`, `evict_req` and `async_en` are 0.
- R2: The threshold field is bits 23:16 of the command register. A write takes effect only when the value is 0x01, 0x02, 0x04, 0x08, 0x10, 0x20 or 0x40. Any other value, including 0x00, leaves the previous threshold in place.
- R3: In the command register, bits 31:24, 15:7 and 4:0 always read 0, and writes to them have no effect.
- R4: Bit 5 of the command register is the schedule enable. It can be written and read back, and it drives `async_en`.
- R5: Writing 1 to bit 6 (the doorbell) in a write that also sets bit 5 sets the doorbell and raises `evict_req` from the next cycle. Writing 0 to bit 6 does not clear a pending doorbell. Any write that leaves bit 5 at 0 leaves the doorbell at 0: it refuses a new ring and cancels a pending one.
- R6: An `evict_done` pulse while the doorbell is set clears the doorbell and `evict_req` and sets status bit 0 (async advance), all in the next cycle. An `evict_done` with no doorbell pending changes nothing.
- R7: A `src_evt[i]` pulse sets status bit i+1. Writing 1s to address 1 clears those status bits. If a bit is set and cleared in the same cycle, the set wins.
- R8: `irq` rises only in the cycle after the tick that completes an interval, and only if an enabled status bit is pending. An interval is N ticks since the last boundary or threshold change, where N is the threshold.
- R9: `irq` falls in the same cycle that no enabled status bit remains pending, whether that happens through a status clear or through an enable clear.
- R10: Writing a new legal threshold that differs from the current one restarts the interval count, so the next boundary falls N ticks later.
- R11: A pending status bit whose enable bit (same position at address 2) is 0 never raises `irq`. Setting that enable bit later does not raise `irq` before the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 command, 1 status, 2 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| src_evt | input | 4 | Status event pulses, one per source |
| evict_done | input | 1 | Schedule engine reports cached async state evicted |
| evict_req | output | 1 | Eviction request to the schedule engine |
| async_en | output | 1 | Asynchronous schedule enable |
| irq | output | 1 | Paced interrupt |

## Verification
If the interval counter goes wrong, the fault shows up at `irq` as a rise that is one or more ticks early or late. A test that counts ticks from a known restart point catches it at the first boundary. A stuck doorbell or a missing hardware clear shows up on `evict_req` in the cycle after `evict_done`. A wrong status or enable bit shows up either as an `irq` that appears with no enabled source, or as an `irq` that stays high after the clear write.

// File: rtl/usb_intr_pacer_pkg.sv
`timescale 1ns/1ps
package usb_intr_pacer_pkg;
  localparam int REG_W   = 32;
  localparam int THR_LSB = 16;
  localparam int THR_W   = 8;
  localparam int DB_BIT  = 6;
  localparam int ASE_BIT = 5;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_ENA  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // a legal threshold is a single set bit no higher than 2**max_log
  function automatic logic thr_is_legal(input logic [THR_W-1:0] v, input int max_log);
    logic [THR_W-1:0] lim;
    lim = THR_W'(1) << max_log;
    return (v != '0) && ((v & (v - THR_W'(1))) == '0) && (v <= lim);
  endfunction

  function automatic logic [REG_W-1:0] pack_cmd(input logic [THR_W-1:0] thr,
                                               input logic db, input logic ase);
    logic [REG_W-1:0] r;
    r = '0;
    r[THR_LSB +: THR_W] = thr;
    r[DB_BIT]  = db;
    r[ASE_BIT] = ase;
    return r;
  endfunction
endpackage

// File: rtl/upc_cmd_slice.sv
`timescale 1ns/1ps
module upc_cmd_slice
  import usb_intr_pacer_pkg::*;
#(
  parameter int               MAX_LOG = 6,
  parameter logic [THR_W-1:0] THR_RST = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [THR_W-1:0] wr_thr,
  input  logic             wr_db,
  input  logic             wr_ase,
  input  logic             evict_done,
  output logic [THR_W-1:0] thr_q,
  output logic             ase_q,
  output logic             db_q,
  output logic             thr_chg,
  output logic             aa_set
);
  // named internal events
  assign thr_chg = wr_cmd && thr_is_legal(wr_thr, MAX_LOG) && (wr_thr != thr_q);
  assign aa_set  = db_q && evict_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      ase_q <= 1'b0;
      db_q  <= 1'b0;
    end else begin
      if (thr_chg) thr_q <= wr_thr;
      if (wr_cmd)  ase_q <= wr_ase;
      if (aa_set)                db_q <= 1'b0;
      else if (wr_cmd && !wr_ase) db_q <= 1'b0;
      else if (wr_cmd && wr_db)  db_q <= 1'b1;
    end
  end

  a_r2_thr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    thr_is_legal(thr_q, MAX_LOG));
  a_r5_db_needs_ase: assert property (@(posedge clk) disable iff (!rst_n)
    db_q |-> ase_q);
  a_r6_db_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    aa_set |=> !db_q);
  a_r2_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !thr_is_legal(wr_thr, MAX_LOG)) |=> $stable(thr_q));
endmodule

// File: rtl/upc_interval_timer.sv
`timescale 1ns/1ps
module upc_interval_timer
  import usb_intr_pacer_pkg::*;
#(
  parameter int MAX_LOG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [THR_W-1:0] thr,
  output logic             boundary
);
  localparam int CNT_W = MAX_LOG + 1;

  logic [CNT_W-1:0] cnt_q;

  assign boundary = tick && !restart && (THR_W'(cnt_q) == (thr - THR_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (boundary) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r8_cnt_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
    THR_W'(cnt_q) < thr);
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/upc_status_irq.sv
`timescale 1ns/1ps
module upc_status_irq #(
  parameter int NSTS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTS-1:0] set_vec,
  input  logic [NSTS-1:0] clr_vec,
  input  logic            ena_wr,
  input  logic [NSTS-1:0] ena_wdata,
  input  logic            boundary,
  output logic [NSTS-1:0] sts_q,
  output logic [NSTS-1:0] ena_q,
  output logic            pend_any,
  output logic            irq
);
  logic irq_q;

  assign pend_any = |(sts_q & ena_q);
  assign irq      = irq_q && pend_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (ena_wr) ena_q <= ena_wdata;
      irq_q <= (irq_q || boundary) && pend_any;
    end
  end

  a_r8_rise_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(boundary));
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/usb_intr_pacer.sv
`timescale 1ns/1ps
module usb_intr_pacer
  import usb_intr_pacer_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int MAX_LOG = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic               uframe_tick,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               evict_done,
  output logic               evict_req,
  output logic               async_en,
  output logic               irq
);
  localparam int NSTS = NUM_SRC + 1;

  reg_sel_e         sel;
  logic             wr_cmd, wr_sts, wr_ena;
  logic [THR_W-1:0] thr_q;
  logic             ase_q, db_q, thr_chg, aa_set, boundary, pend_any;
  logic [NSTS-1:0]  sts_q, ena_q, set_vec, clr_vec;
  logic             unused_wdata;

  assign sel    = reg_sel_e'(bus_addr);
  assign wr_cmd = bus_wr && (sel == SEL_CMD);
  assign wr_sts = bus_wr && (sel == SEL_STS);
  assign wr_ena = bus_wr && (sel == SEL_ENA);
  assign unused_wdata = ^bus_wdata;

  assign set_vec = {src_evt, aa_set};
  assign clr_vec = wr_sts ? bus_wdata[NSTS-1:0] : '0;

  upc_cmd_slice #(.MAX_LOG(MAX_LOG)) cmd_i (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .wr_thr(bus_wdata[THR_LSB +: THR_W]), .wr_db(bus_wdata[DB_BIT]),
    .wr_ase(bus_wdata[ASE_BIT]), .evict_done(evict_done),
    .thr_q(thr_q), .ase_q(ase_q), .db_q(db_q),
    .thr_chg(thr_chg), .aa_set(aa_set)
  );

  upc_interval_timer #(.MAX_LOG(MAX_LOG)) tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .restart(thr_chg),
    .thr(thr_q), .boundary(boundary)
  );

  upc_status_irq #(.NSTS(NSTS)) sts_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .ena_wr(wr_ena), .ena_wdata(bus_wdata[NSTS-1:0]), .boundary(boundary),
    .sts_q(sts_q), .ena_q(ena_q), .pend_any(pend_any), .irq(irq)
  );

  assign evict_req = db_q;
  assign async_en  = ase_q;

  always_comb begin
    unique case (sel)
      SEL_CMD: bus_rdata = pack_cmd(thr_q, db_q, ase_q);
      SEL_STS: bus_rdata = REG_W'(sts_q);
      SEL_ENA: bus_rdata = REG_W'(ena_q);
      default: bus_rdata = '0;
    endcase
  end

  a_r6_aa_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_req && evict_done) |=> (sts_q[0] && !evict_req));
  a_r6_stray_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!evict_req && !src_evt[0] && !wr_cmd && !wr_sts && !sts_q[0]) |=> !sts_q[0]);
  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(sts_q & ena_q)));
endmodule

// File: tb/usb_intr_pacer_tb_top.sv
`timescale 1ns/1ps
module usb_intr_pacer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        uframe_tick = 1'b0;
  logic [3:0]  src_evt = '0;
  logic        evict_done = 1'b0;
  logic        evict_req, async_en, irq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  usb_intr_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uframe_tick(uframe_tick),
    .src_evt(src_evt), .evict_done(evict_done), .evict_req(evict_req),
    .async_en(async_en), .irq(irq)
  );

  // threshold write value and the value expected to read back afterwards
  localparam int NV = 10;
  localparam logic [15:0] THR_VEC [NV] = '{
    {8'h04, 8'h04}, {8'h00, 8'h04}, {8'h03, 8'h04}, {8'h40, 8'h40},
    {8'h80, 8'h40}, {8'h01, 8'h01}, {8'h41, 8'h01}, {8'h20, 8'h20},
    {8'hFF, 8'h20}, {8'h10, 8'h10}
  };

  function automatic logic [31:0] cmd_word(input logic [7:0] thr, input logic db,
                                           input logic ase);
    return {8'h00, thr, 9'h000, db, ase, 5'h00};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); uframe_tick = 1'b1;
      @(negedge clk); uframe_tick = 1'b0;
    end
  endtask

  task automatic pulse_src(input logic [3:0] v);
    @(negedge clk); src_evt = v;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk(d, 32'h0008_0000, "R1 cmd");
    rd(2'd1, d); chk(d, 32'h0, "R1 sts");
    rd(2'd2, d); chk(d, 32'h0, "R1 ena");
    chk({29'h0, irq, evict_req, async_en}, 32'h0, "R1 outputs");

    // R2 threshold vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, cmd_word(THR_VEC[i][15:8], 1'b0, 1'b0));
      rd(2'd0, d);
      chk({24'h0, d[23:16]}, {24'h0, THR_VEC[i][7:0]}, "R2 threshold");
    end

    // R3 read-only bits
    wr(2'd0, 32'hFFFF_FF9F);
    rd(2'd0, d); chk(d, 32'h0010_0000, "R3 reserved bits");

    // R4 schedule enable, threshold 4 (counter restarts)
    wr(2'd0, cmd_word(8'h04, 1'b0, 1'b1));
    rd(2'd0, d); chk(d, 32'h0004_0020, "R4 readback");
    chk({31'h0, async_en}, 32'h1, "R4 async_en");

    // R5 ring refused when enable written 0
    wr(2'd0, cmd_word(8'h04, 1'b1, 1'b0));
    rd(2'd0, d); chk(d, 32'h0004_0000, "R5 refused ring");
    chk({31'h0, evict_req}, 32'h0, "R5 no request");
    wr(2'd0, cmd_word(8'h04, 1'b0, 1'b1));

    // R6 stray eviction report ignored
    @(negedge clk); evict_done = 1'b1;
    @(negedge clk); evict_done = 1'b0;
    rd(2'd1, d); chk(d, 32'h0, "R6 stray done");

    // R5 ring, then write 0 to doorbell has no effect
    wr(2'd0, cmd_word(8'h04, 1'b1, 1'b1));
    chk({31'h0, evict_req}, 32'h1, "R5 request raised");
    rd(2'd0, d); chk(d, 32'h0004_0060, "R5 doorbell reads 1");
    wr(2'd0, cmd_word(8'h04, 1'b0, 1'b1));
    chk({31'h0, evict_req}, 32'h1, "R5 write 0 ignored");

    // R6 eviction handshake
    @(negedge clk); evict_done = 1'b1;
    @(negedge clk); evict_done = 1'b0;
    chk({31'h0, evict_req}, 32'h0, "R6 request dropped");
    rd(2'd0, d); chk(d, 32'h0004_0020, "R6 doorbell cleared");
    rd(2'd1, d); chk(d, 32'h1, "R6 async status");

    // R11 pending but disabled, then enabled: waits for boundary
    ticks(4);
    chk({31'h0, irq}, 32'h0, "R11 disabled source");
    wr(2'd2, 32'h1);
    chk({31'h0, irq}, 32'h0, "R11 no immediate irq");
    ticks(3);
    chk({31'h0, irq}, 32'h0, "R8 before boundary");
    ticks(1);
    chk({31'h0, irq}, 32'h1, "R8 at boundary");

    // R9 clear status drops irq
    wr(2'd1, 32'h1);
    chk({31'h0, irq}, 32'h0, "R9 drop on clear");
    rd(2'd1, d); chk(d, 32'h0, "R7 status cleared");

    // R7 source event, R8 again, R9 via enable clear
    pulse_src(4'b0100);
    rd(2'd1, d); chk(d, 32'h8, "R7 source sets bit");
    wr(2'd2, 32'h1F);
    ticks(4);
    chk({31'h0, irq}, 32'h1, "R8 source irq");
    wr(2'd2, 32'h0);
    chk({31'h0, irq}, 32'h0, "R9 drop on enable clear");

    // R7 set wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h8; src_evt = 4'b0100;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; src_evt = '0;
    rd(2'd1, d); chk(d, 32'h8, "R7 set wins");
    wr(2'd1, 32'h8);
    rd(2'd1, d); chk(d, 32'h0, "R7 second clear");

    // R10 threshold change restarts the count
    wr(2'd2, 32'h1F);
    pulse_src(4'b0001);
    ticks(2);
    chk({31'h0, irq}, 32'h0, "R10 mid interval");
    wr(2'd0, cmd_word(8'h02, 1'b0, 1'b1));
    ticks(1);
    chk({31'h0, irq}, 32'h0, "R10 one tick after change");
    ticks(1);
    chk({31'h0, irq}, 32'h1, "R10 new interval boundary");

    done = 1'b1;
    finish_run();
  end
endmodule